// File: doc/BRIEF.md
# Serial Command Front-End for a Digital Potentiometer

This block is the serial slave side of a digitally controlled potentiometer. It receives frames on a four-wire serial bus (select, clock, data in, data out) with a pause input, checks that each frame is addressed to this device, and decodes the command. It hands that command to a separate register controller. Register storage, non-volatile write timing and the resistor array sit outside the block.

Every input pin is brought into the system clock domain through two flops. Serial clock edges are found by comparing successive synchronized samples. A frame starts with an identity byte and an instruction byte. Transfer commands stop there. Reads and writes carry two more bytes that hold a 10-bit value, right-aligned. Read data is fetched from the controller after the instruction byte and shifted out MSB first. Write and transfer commands are reported only when the frame closes cleanly.

Top module: `dpot_spi_front`

## Requirements
- R1: After reset `so_oe`, `cmd_valid` and `rd_req` are 0. A frame is accepted only after a high-to-low transition of `cs_n` has been seen since reset, so a frame clocked while `cs_n` was already low at reset produces no request.
- R2: SI is sampled on SCK rising edges, MSB first. A 32-bit frame made of identity byte `0101_00_A_0`, instruction `101_0_00_00`, byte `000000,d[9:8]` and byte `d[7:0]` gives one single-cycle `cmd_valid` after `cs_n` rises, with `cmd_op`=2 (write wiper) and `cmd_data`=d.
- R3: The identity byte must carry 0101 in bits 7:4, zeros in bits 3:2, and the level of `addr_pin` in bit 1. Bit 0 is the read flag. A frame that fails this check produces no request and never enables SO.
- R4: Write flag 0 with instruction bits 7:5 = 110 is a data register write: `cmd_op`=4, `cmd_reg` = instruction bits 3:2, and `cmd_data` is taken as in R2.
- R5: A 16-bit frame with read flag 1 and instruction 110 gives `cmd_op`=5 (register to wiper). With read flag 0 and instruction 111 it gives `cmd_op`=6 (wiper to register). In both cases `cmd_reg` = instruction bits 3:2 and the request is reported when `cs_n` rises.
- R6: Read flag 1 with instruction 100 (`cmd_op`=1, wiper) or 101 (`cmd_op`=3, register `cmd_reg`) pulses `rd_req` for one cycle after the instruction byte. `rd_data` is captured on the following cycle. SO then carries `000000,rd_data[9:0]` in the last 16 bits, MSB first, changing on SCK falling edges, with `so_oe` high.
- R7: Read flag 1 with instruction byte `010_0_00_01` is a status read (`cmd_op`=7, `rd_req` pulse). SO returns 15 zeros and then the `wip` level captured as in R6.
- R8: A write or transfer frame whose bit count differs from its exact length (32 or 16) is discarded and produces no `cmd_valid`.
- R9: Undefined combinations are ignored until `cs_n` rises, with no request and no SO enable. This covers any read flag and opcode pair not listed, a nonzero bit 4 in the instruction, nonzero bits 1:0 outside status, and a status byte with other low bits.
- R10: When `hold_n` goes low while SCK is low, the transfer pauses. SCK edges are ignored and `so_oe` is low. When `hold_n` returns high while SCK is low, the transfer continues from the same bit.
- R11: While `cs_n` is high, `so_oe` is low and the frame is reset. A frame abandoned partway leaves no trace on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| addr_pin | input | 1 | Static device address strap |
| wip | input | 1 | Write-in-progress level from the controller |
| rd_data | input | 10 | Read value from the controller |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO |
| rd_req | output | 1 | Read request pulse |
| cmd_valid | output | 1 | Write or transfer command pulse |
| cmd_op | output | 3 | Command code |
| cmd_reg | output | 2 | Data register index |
| cmd_data | output | 10 | Write value |

## Verification
Write frames use values that have both of the top two bits set and values with alternating bit patterns. A swapped byte or a lost top bit therefore shows up as a wrong value, not as a value that happens to match. Transfer and register frames use different register indices, so a mis-sliced pointer shows up. Negative frames cover an address mismatch, a wrong identity nibble, an undefined opcode, a truncated write and an overlong transfer. Each must leave no request and keep SO disabled. Pauses are placed mid-byte in both a write and a read, which tells a correct resume apart from a lost or doubled bit.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int BYTE_BITS  = 8;
    localparam int FRAME_BITS = 32;
    localparam int SHORT_BITS = 16;
    localparam int DATA_W     = 10;
    localparam int TX_W       = 16;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_RD_WIPER  = 3'd1,
        OP_WR_WIPER  = 3'd2,
        OP_RD_DREG   = 3'd3,
        OP_WR_DREG   = 3'd4,
        OP_XFR_D2W   = 3'd5,
        OP_XFR_W2D   = 3'd6,
        OP_RD_STATUS = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_IDENT,
        PH_INSTR,
        PH_DATA,
        PH_DONE,
        PH_DROP
    } phase_e;

    function automatic op_e decode_op(input logic rd_flag, input logic [7:0] ib);
        op_e res;
        res = OP_NONE;
        if (ib[4] == 1'b0) begin
            case ({rd_flag, ib[7:5]})
                4'b1100: res = (ib[1:0] == 2'b00) ? OP_RD_WIPER : OP_NONE;
                4'b0101: res = (ib[1:0] == 2'b00) ? OP_WR_WIPER : OP_NONE;
                4'b1101: res = (ib[1:0] == 2'b00) ? OP_RD_DREG  : OP_NONE;
                4'b0110: res = (ib[1:0] == 2'b00) ? OP_WR_DREG  : OP_NONE;
                4'b1110: res = (ib[1:0] == 2'b00) ? OP_XFR_D2W  : OP_NONE;
                4'b0111: res = (ib[1:0] == 2'b00) ? OP_XFR_W2D  : OP_NONE;
                4'b1010: res = (ib[3:0] == 4'b0001) ? OP_RD_STATUS : OP_NONE;
                default: res = OP_NONE;
            endcase
        end
        return res;
    endfunction

    function automatic logic is_read(input op_e op);
        return (op == OP_RD_WIPER) || (op == OP_RD_DREG) || (op == OP_RD_STATUS);
    endfunction

    function automatic logic is_short(input op_e op);
        return (op == OP_XFR_D2W) || (op == OP_XFR_W2D);
    endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dpot_edge_hold.sv
module dpot_edge_hold (
    input  logic clk,
    input  logic rst,
    input  logic s_sck,
    input  logic s_hold_n,
    output logic rise,
    output logic fall,
    output logic paused
);
    logic sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            paused <= 1'b0;
        end else begin
            sck_d <= s_sck;
            // the pause state may only change while the serial clock is low
            if (!s_sck) paused <= ~s_hold_n;
        end
    end

    assign rise = s_sck & ~sck_d & ~paused;
    assign fall = ~s_sck & sck_d & ~paused;
endmodule

// File: rtl/dpot_frame.sv
module dpot_frame
    import dpot_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'b0101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_cs_n,
    input  logic              s_si,
    input  logic              rise,
    input  logic              addr_pin,
    input  logic              wip,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [1:0]        cmd_reg,
    output logic [DATA_W-1:0] cmd_data,
    output logic              rd_req,
    output logic              rd_mode,
    output logic              tx_load,
    output logic [TX_W-1:0]   tx_word
);
    localparam int CNT_W     = $clog2(FRAME_BITS);
    localparam int ID_LAST   = BYTE_BITS - 1;
    localparam int IN_LAST   = 2 * BYTE_BITS - 1;
    localparam int HI_LAST   = 3 * BYTE_BITS - 1;
    localparam int LO_LAST   = FRAME_BITS - 1;
    localparam int HI_W      = DATA_W - BYTE_BITS;

    phase_e                   phase;
    logic [CNT_W-1:0]         cnt;
    logic [BYTE_BITS-2:0]     sh;
    logic                     rd_flag;
    logic                     cs_d;
    logic [BYTE_BITS-1:0]     byte_now;
    op_e                      op_new;

    assign byte_now = {sh, s_si};
    assign op_new   = decode_op(rd_flag, byte_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            sh        <= '0;
            rd_flag   <= 1'b0;
            cs_d      <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
            cmd_reg   <= '0;
            cmd_data  <= '0;
            rd_req    <= 1'b0;
            rd_mode   <= 1'b0;
            tx_load   <= 1'b0;
            tx_word   <= '0;
        end else begin
            cs_d      <= s_cs_n;
            cmd_valid <= 1'b0;
            rd_req    <= 1'b0;
            tx_load   <= rd_req;
            if (rd_req) begin
                if (cmd_op == OP_RD_STATUS) tx_word <= {{(TX_W-1){1'b0}}, wip};
                else                        tx_word <= {{(TX_W-DATA_W){1'b0}}, rd_data};
            end
            if (s_cs_n) begin
                if (!cs_d && phase == PH_DONE && !is_read(cmd_op)) cmd_valid <= 1'b1;
                phase   <= PH_IDLE;
                cnt     <= '0;
                rd_mode <= 1'b0;
            end else if (cs_d) begin
                phase <= PH_IDENT;
                cnt   <= '0;
            end else if (rise) begin
                sh  <= byte_now[BYTE_BITS-2:0];
                cnt <= cnt + 1'b1;
                case (phase)
                    PH_IDENT: if (cnt == CNT_W'(ID_LAST)) begin
                        rd_flag <= s_si;
                        if (byte_now[7:4] == DEV_ID && byte_now[3:2] == 2'b00 &&
                            byte_now[1] == addr_pin)
                            phase <= PH_INSTR;
                        else
                            phase <= PH_DROP;
                    end
                    PH_INSTR: if (cnt == CNT_W'(IN_LAST)) begin
                        if (op_new == OP_NONE) begin
                            phase <= PH_DROP;
                        end else begin
                            cmd_op  <= op_new;
                            cmd_reg <= byte_now[3:2];
                            phase   <= is_short(op_new) ? PH_DONE : PH_DATA;
                            if (is_read(op_new)) begin
                                rd_req  <= 1'b1;
                                rd_mode <= 1'b1;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (cnt == CNT_W'(HI_LAST))
                            cmd_data[DATA_W-1 -: HI_W] <= byte_now[HI_W-1:0];
                        if (cnt == CNT_W'(LO_LAST)) begin
                            cmd_data[BYTE_BITS-1:0] <= byte_now;
                            phase <= PH_DONE;
                        end
                    end
                    PH_DONE: begin
                        phase   <= PH_DROP;
                        rd_mode <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dpot_tx.sv
module dpot_tx
    import dpot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            s_cs_n,
    input  logic            fall,
    input  logic            paused,
    input  logic            active,
    input  logic            load,
    input  logic [TX_W-1:0] word,
    output logic            so,
    output logic            so_oe
);
    logic [TX_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || s_cs_n) begin
            sh    <= '0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else begin
            if (load) begin
                sh <= word;
                so <= 1'b0;
            end else if (fall && active) begin
                so <= sh[TX_W-1];
                sh <= {sh[TX_W-2:0], 1'b0};
            end
            so_oe <= active & ~paused;
        end
    end
endmodule

// File: rtl/dpot_spi_front.sv
module dpot_spi_front
    import dpot_pkg::*;
#(
    parameter logic [3:0] DEV_ID      = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic              addr_pin,
    input  logic              wip,
    input  logic [DATA_W-1:0] rd_data,
    output logic              so,
    output logic              so_oe,
    output logic              rd_req,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [1:0]        cmd_reg,
    output logic [DATA_W-1:0] cmd_data
);
    // pin order in the synchronizer: {hold_n, si, sck, cs_n}
    localparam logic [3:0] SYNC_RST = 4'b1000;

    logic [3:0]      s_pins;
    logic            s_cs_n, s_sck, s_si, s_hold_n;
    logic            rise, fall, paused;
    logic            rd_mode, tx_load;
    logic [TX_W-1:0] tx_word;
    op_e             op_q;

    dpot_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({hold_n, si, sck, cs_n}),
        .q   (s_pins)
    );
    assign {s_hold_n, s_si, s_sck, s_cs_n} = s_pins;

    dpot_edge_hold u_edge (
        .clk      (clk),
        .rst      (rst),
        .s_sck    (s_sck),
        .s_hold_n (s_hold_n),
        .rise     (rise),
        .fall     (fall),
        .paused   (paused)
    );

    dpot_frame #(.DEV_ID(DEV_ID)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .s_cs_n    (s_cs_n),
        .s_si      (s_si),
        .rise      (rise),
        .addr_pin  (addr_pin),
        .wip       (wip),
        .rd_data   (rd_data),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_q),
        .cmd_reg   (cmd_reg),
        .cmd_data  (cmd_data),
        .rd_req    (rd_req),
        .rd_mode   (rd_mode),
        .tx_load   (tx_load),
        .tx_word   (tx_word)
    );
    assign cmd_op = op_q;

    dpot_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .s_cs_n (s_cs_n),
        .fall   (fall),
        .paused (paused),
        .active (rd_mode),
        .load   (tx_load),
        .word   (tx_word),
        .so     (so),
        .so_oe  (so_oe)
    );
endmodule

// File: rtl/dpot_spi_front_chk.sv
module dpot_spi_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       s_cs_n,
    input logic       paused,
    input logic       so_oe,
    input logic       cmd_valid,
    input logic       rd_req,
    input logic [2:0] cmd_op
);
    // R11
    cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        s_cs_n |=> !so_oe);

    // R10
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        paused |=> !so_oe);

    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R6
    rdreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R8
    cmd_at_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(s_cs_n));

    // R9
    cmd_op_kind_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op == 3'd2 || cmd_op == 3'd4 || cmd_op == 3'd5 || cmd_op == 3'd6));

    // R6
    rdreq_op_kind_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (cmd_op == 3'd1 || cmd_op == 3'd3 || cmd_op == 3'd7));
endmodule

bind dpot_spi_front dpot_spi_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_cs_n    (s_cs_n),
    .paused    (paused),
    .so_oe     (so_oe),
    .cmd_valid (cmd_valid),
    .rd_req    (rd_req),
    .cmd_op    (cmd_op)
);

// File: tb/tb_dpot_spi_front.sv
module tb_dpot_spi_front;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic       addr_pin = 1'b0;
    logic       wip = 1'b0;
    logic [9:0] rd_data = '0;
    logic       so, so_oe, rd_req, cmd_valid;
    logic [2:0] cmd_op;
    logic [1:0] cmd_reg;
    logic [9:0] cmd_data;

    int total = 0;
    int bad = 0;
    bit oe_seen = 0;

    typedef struct {
        bit         is_rd;
        logic [2:0] op;
        logic [1:0] rg;
        logic [9:0] data;
        bit         chk_data;
        string      req;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    dpot_spi_front dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .addr_pin(addr_pin), .wip(wip), .rd_data(rd_data), .so(so), .so_oe(so_oe),
        .rd_req(rd_req), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
        .cmd_data(cmd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every request the design emits
    always @(negedge clk) begin
        if (so_oe) oe_seen = 1;
        if (!rst && (cmd_valid || rd_req)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3", "unexpected request op", int'(cmd_op), 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(e.is_rd == rd_req && e.op == cmd_op && e.rg == cmd_reg,
                    e.req, "request kind/op/reg", {rd_req, cmd_op, cmd_reg},
                    {e.is_rd, e.op, e.rg});
                if (e.chk_data)
                    chk(cmd_data == e.data, e.req, "write data", cmd_data, e.data);
            end
        end
    end

    initial begin
        #(200000 * 10);
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input bit is_rd, input logic [2:0] op, input logic [1:0] rg,
                        input logic [9:0] d, input bit cd, input string req);
        item_t e;
        e.is_rd = is_rd; e.op = op; e.rg = rg; e.data = d; e.chk_data = cd; e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic logic [31:0] mk(input logic [3:0] id, input logic a, input logic rw,
                                       input logic [7:0] ib, input logic [9:0] d);
        return {id, 2'b00, a, rw, ib, 6'b000000, d};
    endfunction

    task automatic run_frame(input bit lower_cs, input int nbits, input logic [31:0] bits,
                             input int hold_at, output logic [15:0] rx, output bit oe_ok);
        rx = '0;
        oe_ok = 1;
        oe_seen = 0;
        if (lower_cs) cs_n = 1'b0;
        wclk(8);
        for (int i = 0; i < nbits; i++) begin
            if (i == hold_at) begin
                hold_n = 1'b0; wclk(6);
                sck = 1'b1; wclk(6); sck = 1'b0; wclk(6);
                sck = 1'b1; wclk(6); sck = 1'b0; wclk(6);
                chk(so_oe == 1'b0, "R10", "so_oe during pause", so_oe, 0);
                hold_n = 1'b1; wclk(6);
            end
            si = bits[31-i];
            wclk(8);
            if (i >= 16) begin
                rx = {rx[14:0], so};
                if (!so_oe) oe_ok = 0;
            end
            sck = 1'b1; wclk(8); sck = 1'b0;
        end
        wclk(8);
        cs_n = 1'b1;
        wclk(12);
        chk(so_oe == 1'b0, "R11", "so_oe with cs high", so_oe, 0);
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, "missing requests", exp_q.size(), 0);
    endtask

    initial begin
        logic [15:0] rx;
        bit ok;
        wclk(4);
        rst = 1'b0;
        wclk(2);
        // R1 reset state
        chk(so_oe == 0 && cmd_valid == 0 && rd_req == 0, "R1", "reset outputs",
            {so_oe, cmd_valid, rd_req}, 0);
        // R1 cs low through reset: no falling edge yet, frame ignored
        run_frame(0, 32, mk(4'b0101, 0, 0, 8'b101_0_00_00, 10'h155), -1, rx, ok);
        drained("R1");
        chk(!oe_seen, "R1", "so enabled without cs fall", oe_seen, 0);

        // R2 write wiper, both top bits set
        push(0, 3'd2, 2'd0, 10'h3C5, 1, "R2");
        run_frame(1, 32, mk(4'b0101, 0, 0, 8'b101_0_00_00, 10'h3C5), -1, rx, ok);
        drained("R2");
        // R2 R3 address pin high
        addr_pin = 1'b1;
        push(0, 3'd2, 2'd0, 10'h2AA, 1, "R2");
        run_frame(1, 32, mk(4'b0101, 1, 0, 8'b101_0_00_00, 10'h2AA), -1, rx, ok);
        drained("R2");
        // R3 address mismatch
        run_frame(1, 32, mk(4'b0101, 0, 0, 8'b101_0_00_00, 10'h111), -1, rx, ok);
        drained("R3");
        // R3 wrong identity nibble on a read
        run_frame(1, 32, mk(4'b0110, 1, 1, 8'b100_0_00_00, 10'h0), -1, rx, ok);
        drained("R3");
        chk(!oe_seen, "R3", "so enabled on bad id", oe_seen, 0);
        addr_pin = 1'b0;

        // R4 write data registers
        push(0, 3'd4, 2'd2, 10'h155, 1, "R4");
        run_frame(1, 32, mk(4'b0101, 0, 0, 8'b110_0_10_00, 10'h155), -1, rx, ok);
        push(0, 3'd4, 2'd3, 10'h201, 1, "R4");
        run_frame(1, 32, mk(4'b0101, 0, 0, 8'b110_0_11_00, 10'h201), -1, rx, ok);
        drained("R4");

        // R5 transfers
        push(0, 3'd5, 2'd1, 10'h0, 0, "R5");
        run_frame(1, 16, mk(4'b0101, 0, 1, 8'b110_0_01_00, 10'h0), -1, rx, ok);
        push(0, 3'd6, 2'd3, 10'h0, 0, "R5");
        run_frame(1, 16, mk(4'b0101, 0, 0, 8'b111_0_11_00, 10'h0), -1, rx, ok);
        drained("R5");

        // R6 read wiper
        rd_data = 10'h2C3;
        push(1, 3'd1, 2'd0, 10'h0, 0, "R6");
        run_frame(1, 32, mk(4'b0101, 0, 1, 8'b100_0_00_00, 10'h0), -1, rx, ok);
        chk(rx == 16'h02C3, "R6", "read wiper SO word", rx, 16'h02C3);
        chk(ok, "R6", "so_oe during read data", ok, 1);
        // R6 read data register 2
        rd_data = 10'h1F0;
        push(1, 3'd3, 2'd2, 10'h0, 0, "R6");
        run_frame(1, 32, mk(4'b0101, 0, 1, 8'b101_0_10_00, 10'h0), -1, rx, ok);
        chk(rx == 16'h01F0, "R6", "read register SO word", rx, 16'h01F0);
        drained("R6");

        // R7 status
        wip = 1'b1;
        push(1, 3'd7, 2'd0, 10'h0, 0, "R7");
        run_frame(1, 32, {4'b0101, 2'b00, 1'b0, 1'b1, 8'b010_0_00_01, 16'h0}, -1, rx, ok);
        chk(rx == 16'h0001, "R7", "status busy", rx, 1);
        wip = 1'b0;
        push(1, 3'd7, 2'd0, 10'h0, 0, "R7");
        run_frame(1, 32, {4'b0101, 2'b00, 1'b0, 1'b1, 8'b010_0_00_01, 16'h0}, -1, rx, ok);
        chk(rx == 16'h0000, "R7", "status idle", rx, 0);
        drained("R7");

        // R8 truncated write, overlong transfer
        run_frame(1, 24, mk(4'b0101, 0, 0, 8'b101_0_00_00, 10'h3FF), -1, rx, ok);
        run_frame(1, 24, mk(4'b0101, 0, 0, 8'b111_0_01_00, 10'h0), -1, rx, ok);
        drained("R8");

        // R9 undefined: write flag with opcode 100, and nonzero bit 4
        run_frame(1, 32, mk(4'b0101, 0, 0, 8'b100_0_00_00, 10'h123), -1, rx, ok);
        run_frame(1, 32, mk(4'b0101, 0, 1, 8'b101_1_00_00, 10'h0), -1, rx, ok);
        drained("R9");
        chk(!oe_seen, "R9", "so enabled on undefined op", oe_seen, 0);

        // R10 pause in a write and in a read
        push(0, 3'd2, 2'd0, 10'h2B6, 1, "R10");
        run_frame(1, 32, mk(4'b0101, 0, 0, 8'b101_0_00_00, 10'h2B6), 27, rx, ok);
        drained("R10");
        rd_data = 10'h35A;
        push(1, 3'd1, 2'd0, 10'h0, 0, "R10");
        run_frame(1, 32, mk(4'b0101, 0, 1, 8'b100_0_00_00, 10'h0), 21, rx, ok);
        chk(rx == 16'h035A, "R10", "read word across pause", rx, 16'h035A);
        drained("R10");

        // R11 aborted frame then a clean one
        run_frame(1, 11, mk(4'b0101, 0, 0, 8'b101_0_00_00, 10'h0), -1, rx, ok);
        push(0, 3'd4, 2'd1, 10'h0F3, 1, "R11");
        run_frame(1, 32, mk(4'b0101, 0, 0, 8'b110_0_01_00, 10'h0F3), -1, rx, ok);
        drained("R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule